// File: doc/BRIEF.md
# Two-Group ADC Conversion Sequencer

This block orders the channel selections of an analog-to-digital converter that serves two conversion lists. The regular list holds up to sixteen slots and is meant for background scanning. The injected list holds up to four slots, takes priority and preempts the regular list between conversions. Each slot names any of the converter's input channels. A channel may appear in several slots, in any order.

Software-style write strobes program both lists, and start and stop pulses control each list. The block issues a one-cycle start pulse together with a 5-bit channel code. It then waits for the converter's done strobe and tags the finished result with its group and slot number. Writes that change a list while that list runs are not blocked. They raise a sticky illegal-write flag instead. Dropping the enable input clears all sequencing state and that flag. With the context queue enabled, the injected list may be rewritten while it runs: the new contents wait as one pending context and are loaded when the current injected run ends.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A length value N makes a list run N+1 conversions, in slots 0 to N in order. The regular length is 4 bits and the injected length is 2 bits. Each start carries on `conv_ch` the 5-bit channel programmed for that slot. In `inj_chs_in`, injected slot k sits at bits [5k+4:5k].
- R2: `conv_start` lasts one cycle. At most one conversion is outstanding. `conv_ch` holds steady from a start until that conversion's result is reported.
- R3: Each accepted `conv_done` yields one `res_valid` pulse. `res_inj` is 1 for an injected result and 0 for a regular one, and `res_slot` gives the slot. The group's end-of-conversion flag (`reg_eoc` or `inj_eoc`) pulses with it, and the other group's flags stay 0.
- R4: The last slot of a list also pulses that group's end-of-sequence flag, and the list's busy output then falls.
- R5: An injected start arriving during a regular conversion waits for that conversion to finish. The whole injected list then runs, and the regular list resumes at its next slot.
- R6: A regular slot or length write while `reg_busy` is 1 sets `illegal_wr`. The write still takes effect. `illegal_wr` stays set while `enable` is 1.
- R7: With `queue_en` = 0, an injected write while `inj_busy` is 1 sets `illegal_wr`. It takes effect at once, so the slots that follow use the new channels.
- R8: With `queue_en` = 1, an injected write while `inj_busy` is 1 leaves `illegal_wr` clear and does not alter the running list. It is loaded when that list ends, so the next injected run uses it.
- R9: While `enable` is 0, both busy outputs, the pending context and `illegal_wr` clear, and start pulses are ignored.
- R10: `reg_stop` ends the regular list with no further regular starts. An outstanding regular conversion still reports its result with `reg_eoc` but without `reg_eos`. The next `reg_start` begins at slot 0. A stop in the same cycle as a start wins.
- R11: After reset, `conv_start`, `res_valid`, both busy outputs, `illegal_wr` and `conv_ch` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; 0 clears all sequencing state |
| queue_en | input | 1 | Allows injected rewrites during a run, held as a pending context |
| reg_slot_we | input | 1 | Write strobe for one regular slot |
| reg_slot_idx | input | 4 | Regular slot being written |
| reg_slot_ch | input | 5 | Channel code for that slot |
| reg_len_we | input | 1 | Write strobe for the regular length |
| reg_len_in | input | 4 | Regular length (conversions minus one) |
| inj_we | input | 1 | Write strobe for the whole injected list |
| inj_len_in | input | 2 | Injected length (conversions minus one) |
| inj_chs_in | input | 20 | Injected channels, slot k at [5k+4:5k] |
| reg_start | input | 1 | Start pulse for the regular list |
| reg_stop | input | 1 | Stop pulse for the regular list |
| inj_start | input | 1 | Start pulse for the injected list |
| conv_done | input | 1 | Conversion-finished strobe from the converter |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_ch | output | 5 | Channel to convert |
| res_valid | output | 1 | Result tag valid |
| res_inj | output | 1 | Result group: 1 injected, 0 regular |
| res_slot | output | 4 | Slot number of the result |
| reg_eoc | output | 1 | Regular end of conversion |
| reg_eos | output | 1 | Regular end of sequence |
| inj_eoc | output | 1 | Injected end of conversion |
| inj_eos | output | 1 | Injected end of sequence |
| reg_busy | output | 1 | Regular list active |
| inj_busy | output | 1 | Injected list pending or active |
| illegal_wr | output | 1 | Sticky forbidden-write flag |

## Verification
The hardest cases to reach from the ports are the ones that need an event to land while a particular conversion is outstanding: an injected start, a stop, or a configuration write. The bench's converter model answers each start after a fixed latency. A monitor logs every start and every result. The stimulus watches the count of logged starts and fires the event as soon as the chosen slot has been issued. The latency leaves room, so that slot is always still outstanding when the event takes effect. The expected order, channels, tags and end flags are then computed in the bench from the programmed lists.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int unsigned CH_CODE_W = 5;
  typedef enum logic {GRP_REG = 1'b0, GRP_INJ = 1'b1} grp_e;
endpackage

// File: rtl/adcseq_cfg.sv
module adcseq_cfg #(
  parameter int REG_SLOTS = 16,
  parameter int INJ_SLOTS = 4,
  parameter int CH_W      = 5,
  parameter int RIW       = 4,
  parameter int IIW       = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic                      queue_en,
  input  logic                      reg_slot_we,
  input  logic [RIW-1:0]            reg_slot_idx,
  input  logic [CH_W-1:0]           reg_slot_ch,
  input  logic                      reg_len_we,
  input  logic [RIW-1:0]            reg_len_in,
  input  logic                      inj_we,
  input  logic [IIW-1:0]            inj_len_in,
  input  logic [INJ_SLOTS*CH_W-1:0] inj_chs_in,
  input  logic                      reg_busy,
  input  logic                      inj_busy,
  input  logic                      inj_seq_end,
  input  logic [RIW-1:0]            reg_idx,
  input  logic [IIW-1:0]            inj_idx,
  output logic [CH_W-1:0]           reg_ch,
  output logic [CH_W-1:0]           inj_ch,
  output logic [RIW-1:0]            reg_len,
  output logic [IIW-1:0]            inj_len,
  output logic                      illegal_wr
);
  logic [REG_SLOTS-1:0][CH_W-1:0] reg_tab_q, reg_tab_d;
  logic [INJ_SLOTS-1:0][CH_W-1:0] inj_tab_q, inj_tab_d;
  logic [INJ_SLOTS-1:0][CH_W-1:0] ctx_tab_q, ctx_tab_d;
  logic [RIW-1:0] reg_len_q, reg_len_d;
  logic [IIW-1:0] inj_len_q, inj_len_d, ctx_len_q, ctx_len_d;
  logic ctx_vld_q, ctx_vld_d, bad_q, bad_d;
  logic ctx_hold, inj_direct, bad_set;

  always_comb begin
    reg_tab_d  = reg_tab_q;
    reg_len_d  = reg_len_q;
    inj_tab_d  = inj_tab_q;
    inj_len_d  = inj_len_q;
    ctx_tab_d  = ctx_tab_q;
    ctx_len_d  = ctx_len_q;
    ctx_vld_d  = ctx_vld_q;
    ctx_hold   = inj_we && inj_busy && queue_en && !inj_seq_end;
    inj_direct = inj_we && !ctx_hold;
    bad_set    = ((reg_slot_we || reg_len_we) && reg_busy) ||
                 (inj_we && inj_busy && !queue_en);
    bad_d      = bad_q || (enable && bad_set);
    if (reg_slot_we) reg_tab_d[reg_slot_idx] = reg_slot_ch;
    if (reg_len_we)  reg_len_d = reg_len_in;
    if (inj_direct) begin
      inj_tab_d = inj_chs_in;
      inj_len_d = inj_len_in;
    end else if (inj_seq_end && ctx_vld_q) begin
      inj_tab_d = ctx_tab_q;
      inj_len_d = ctx_len_q;
    end
    if (ctx_hold) begin
      ctx_vld_d = 1'b1;
      ctx_tab_d = inj_chs_in;
      ctx_len_d = inj_len_in;
    end else if (inj_seq_end) begin
      ctx_vld_d = 1'b0;
    end
    if (!enable) begin
      ctx_vld_d = 1'b0;
      bad_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_tab_q <= '0;
      reg_len_q <= '0;
      inj_tab_q <= '0;
      inj_len_q <= '0;
      ctx_tab_q <= '0;
      ctx_len_q <= '0;
      ctx_vld_q <= 1'b0;
      bad_q     <= 1'b0;
    end else begin
      reg_tab_q <= reg_tab_d;
      reg_len_q <= reg_len_d;
      inj_tab_q <= inj_tab_d;
      inj_len_q <= inj_len_d;
      ctx_tab_q <= ctx_tab_d;
      ctx_len_q <= ctx_len_d;
      ctx_vld_q <= ctx_vld_d;
      bad_q     <= bad_d;
    end
  end

  assign reg_ch     = reg_tab_q[reg_idx];
  assign inj_ch     = inj_tab_q[inj_idx];
  assign reg_len    = reg_len_q;
  assign inj_len    = inj_len_q;
  assign illegal_wr = bad_q;

  // R6: a regular write during a run raises the flag
  p_reg_write_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && reg_busy && (reg_slot_we || reg_len_we)) |=> illegal_wr);
  // R6: the flag is sticky while enabled
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && illegal_wr) |=> illegal_wr);
  // R8: a queued injected write never raises the flag
  p_queue_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !illegal_wr && inj_we && queue_en &&
     !(reg_busy && (reg_slot_we || reg_len_we))) |=> !illegal_wr);
  // R8: a held context leaves the running injected list untouched
  p_ctx_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_we && inj_busy && queue_en && !inj_seq_end) |=> $stable(inj_len));
endmodule

// File: rtl/adcseq_engine.sv
module adcseq_engine
  import adcseq_pkg::*;
#(
  parameter int CH_W = 5,
  parameter int RIW  = 4,
  parameter int IIW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            reg_start,
  input  logic            reg_stop,
  input  logic            inj_start,
  input  logic            conv_done,
  input  logic [CH_W-1:0] reg_ch,
  input  logic [CH_W-1:0] inj_ch,
  input  logic [RIW-1:0]  reg_len,
  input  logic [IIW-1:0]  inj_len,
  output logic [RIW-1:0]  reg_idx,
  output logic [IIW-1:0]  inj_idx,
  output logic            inj_seq_end,
  output logic            reg_busy,
  output logic            inj_busy,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_ch,
  output logic            res_valid,
  output logic            res_inj,
  output logic [RIW-1:0]  res_slot,
  output logic            reg_eoc,
  output logic            reg_eos,
  output logic            inj_eoc,
  output logic            inj_eos
);
  logic           reg_busy_q, reg_busy_d, inj_busy_q, inj_busy_d;
  logic [RIW-1:0] reg_idx_q, reg_idx_d, fl_slot_q, fl_slot_d, res_slot_q, res_slot_d;
  logic [IIW-1:0] inj_idx_q, inj_idx_d;
  logic           flight_q, flight_d, fl_stale_q, fl_stale_d;
  grp_e           fl_grp_q, fl_grp_d, res_grp_q, res_grp_d;
  logic [CH_W-1:0] conv_ch_q, conv_ch_d;
  logic           start_q, start_d, rvalid_q, rvalid_d;
  logic           reoc_q, reoc_d, reos_q, reos_d, ieoc_q, ieoc_d, ieos_q, ieos_d;
  logic           accept, issue, seq_end;

  always_comb begin
    reg_busy_d = reg_busy_q;
    inj_busy_d = inj_busy_q;
    reg_idx_d  = reg_idx_q;
    inj_idx_d  = inj_idx_q;
    flight_d   = flight_q;
    fl_grp_d   = fl_grp_q;
    fl_slot_d  = fl_slot_q;
    fl_stale_d = fl_stale_q;
    conv_ch_d  = conv_ch_q;
    start_d    = 1'b0;
    rvalid_d   = 1'b0;
    res_grp_d  = res_grp_q;
    res_slot_d = res_slot_q;
    reoc_d     = 1'b0;
    reos_d     = 1'b0;
    ieoc_d     = 1'b0;
    ieos_d     = 1'b0;
    seq_end    = 1'b0;
    accept     = flight_q && conv_done;
    issue      = !flight_q && (inj_busy_q || reg_busy_q);

    if (accept) begin
      flight_d   = 1'b0;
      fl_stale_d = 1'b0;
      rvalid_d   = 1'b1;
      res_grp_d  = fl_grp_q;
      res_slot_d = fl_slot_q;
      if (fl_grp_q == GRP_INJ) begin
        ieoc_d = 1'b1;
        if (inj_idx_q == inj_len) begin
          ieos_d     = 1'b1;
          inj_busy_d = 1'b0;
          inj_idx_d  = '0;
          seq_end    = 1'b1;
        end else begin
          inj_idx_d = inj_idx_q + IIW'(1);
        end
      end else begin
        reoc_d = 1'b1;
        if (reg_busy_q && !fl_stale_q) begin
          if (reg_idx_q == reg_len) begin
            reos_d     = 1'b1;
            reg_busy_d = 1'b0;
            reg_idx_d  = '0;
          end else begin
            reg_idx_d = reg_idx_q + RIW'(1);
          end
        end
      end
    end

    if (issue) begin
      flight_d = 1'b1;
      start_d  = 1'b1;
      if (inj_busy_q) begin
        fl_grp_d  = GRP_INJ;
        fl_slot_d = RIW'(inj_idx_q);
        conv_ch_d = inj_ch;
      end else begin
        fl_grp_d  = GRP_REG;
        fl_slot_d = reg_idx_q;
        conv_ch_d = reg_ch;
      end
    end

    if (inj_start && !inj_busy_q) inj_busy_d = 1'b1;
    if (reg_start && !reg_busy_q) reg_busy_d = 1'b1;
    if (reg_stop) begin
      reg_busy_d = 1'b0;
      reg_idx_d  = '0;
      if (flight_q && (fl_grp_q == GRP_REG) && !accept) fl_stale_d = 1'b1;
    end

    if (!enable) begin
      reg_busy_d = 1'b0;
      inj_busy_d = 1'b0;
      reg_idx_d  = '0;
      inj_idx_d  = '0;
      flight_d   = 1'b0;
      fl_stale_d = 1'b0;
      start_d    = 1'b0;
      rvalid_d   = 1'b0;
      reoc_d     = 1'b0;
      reos_d     = 1'b0;
      ieoc_d     = 1'b0;
      ieos_d     = 1'b0;
      seq_end    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_busy_q <= 1'b0;
      inj_busy_q <= 1'b0;
      reg_idx_q  <= '0;
      inj_idx_q  <= '0;
      flight_q   <= 1'b0;
      fl_grp_q   <= GRP_REG;
      fl_slot_q  <= '0;
      fl_stale_q <= 1'b0;
      conv_ch_q  <= '0;
      start_q    <= 1'b0;
      rvalid_q   <= 1'b0;
      res_grp_q  <= GRP_REG;
      res_slot_q <= '0;
      reoc_q     <= 1'b0;
      reos_q     <= 1'b0;
      ieoc_q     <= 1'b0;
      ieos_q     <= 1'b0;
    end else begin
      reg_busy_q <= reg_busy_d;
      inj_busy_q <= inj_busy_d;
      reg_idx_q  <= reg_idx_d;
      inj_idx_q  <= inj_idx_d;
      flight_q   <= flight_d;
      fl_grp_q   <= fl_grp_d;
      fl_slot_q  <= fl_slot_d;
      fl_stale_q <= fl_stale_d;
      conv_ch_q  <= conv_ch_d;
      start_q    <= start_d;
      rvalid_q   <= rvalid_d;
      res_grp_q  <= res_grp_d;
      res_slot_q <= res_slot_d;
      reoc_q     <= reoc_d;
      reos_q     <= reos_d;
      ieoc_q     <= ieoc_d;
      ieos_q     <= ieos_d;
    end
  end

  assign reg_idx     = reg_idx_q;
  assign inj_idx     = inj_idx_q;
  assign inj_seq_end = seq_end;
  assign reg_busy    = reg_busy_q;
  assign inj_busy    = inj_busy_q;
  assign conv_start  = start_q;
  assign conv_ch     = conv_ch_q;
  assign res_valid   = rvalid_q;
  assign res_inj     = (res_grp_q == GRP_INJ);
  assign res_slot    = res_slot_q;
  assign reg_eoc     = reoc_q;
  assign reg_eos     = reos_q;
  assign inj_eoc     = ieoc_q;
  assign inj_eos     = ieos_q;

  // R2: the start strobe lasts a single cycle
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R2: the channel holds while a conversion is outstanding
  p_ch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && flight_q && !conv_done) |=> $stable(conv_ch));
  // R4: an end-of-sequence flag always comes with its end-of-conversion flag
  p_eos_has_eoc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_eos |-> reg_eoc) and (inj_eos |-> inj_eoc));
  // R5: a waiting injected list takes the next conversion
  p_inj_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && res_valid && !res_inj && inj_busy) |=> (conv_start && fl_grp_q == GRP_INJ));
  // R9: disabling idles the sequencer
  p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!reg_busy && !inj_busy && !conv_start && !res_valid));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int REG_SLOTS = 16,
  parameter int INJ_SLOTS = 4,
  parameter int CH_W      = adcseq_pkg::CH_CODE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic                          queue_en,
  input  logic                          reg_slot_we,
  input  logic [$clog2(REG_SLOTS)-1:0]  reg_slot_idx,
  input  logic [CH_W-1:0]               reg_slot_ch,
  input  logic                          reg_len_we,
  input  logic [$clog2(REG_SLOTS)-1:0]  reg_len_in,
  input  logic                          inj_we,
  input  logic [$clog2(INJ_SLOTS)-1:0]  inj_len_in,
  input  logic [INJ_SLOTS*CH_W-1:0]     inj_chs_in,
  input  logic                          reg_start,
  input  logic                          reg_stop,
  input  logic                          inj_start,
  input  logic                          conv_done,
  output logic                          conv_start,
  output logic [CH_W-1:0]               conv_ch,
  output logic                          res_valid,
  output logic                          res_inj,
  output logic [$clog2(REG_SLOTS)-1:0]  res_slot,
  output logic                          reg_eoc,
  output logic                          reg_eos,
  output logic                          inj_eoc,
  output logic                          inj_eos,
  output logic                          reg_busy,
  output logic                          inj_busy,
  output logic                          illegal_wr
);
  localparam int RIW = $clog2(REG_SLOTS);
  localparam int IIW = $clog2(INJ_SLOTS);

  logic [1:0]      rst_pipe;
  logic            rst_n_i;
  logic [RIW-1:0]  reg_idx, reg_len;
  logic [IIW-1:0]  inj_idx, inj_len;
  logic [CH_W-1:0] reg_ch, inj_ch;
  logic            seq_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  adcseq_cfg #(
    .REG_SLOTS(REG_SLOTS), .INJ_SLOTS(INJ_SLOTS), .CH_W(CH_W), .RIW(RIW), .IIW(IIW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n_i), .enable(enable), .queue_en(queue_en),
    .reg_slot_we(reg_slot_we), .reg_slot_idx(reg_slot_idx), .reg_slot_ch(reg_slot_ch),
    .reg_len_we(reg_len_we), .reg_len_in(reg_len_in),
    .inj_we(inj_we), .inj_len_in(inj_len_in), .inj_chs_in(inj_chs_in),
    .reg_busy(reg_busy), .inj_busy(inj_busy), .inj_seq_end(seq_end),
    .reg_idx(reg_idx), .inj_idx(inj_idx),
    .reg_ch(reg_ch), .inj_ch(inj_ch), .reg_len(reg_len), .inj_len(inj_len),
    .illegal_wr(illegal_wr)
  );

  adcseq_engine #(.CH_W(CH_W), .RIW(RIW), .IIW(IIW)) u_eng (
    .clk(clk), .rst_n(rst_n_i), .enable(enable),
    .reg_start(reg_start), .reg_stop(reg_stop), .inj_start(inj_start),
    .conv_done(conv_done), .reg_ch(reg_ch), .inj_ch(inj_ch),
    .reg_len(reg_len), .inj_len(inj_len),
    .reg_idx(reg_idx), .inj_idx(inj_idx), .inj_seq_end(seq_end),
    .reg_busy(reg_busy), .inj_busy(inj_busy),
    .conv_start(conv_start), .conv_ch(conv_ch),
    .res_valid(res_valid), .res_inj(res_inj), .res_slot(res_slot),
    .reg_eoc(reg_eoc), .reg_eos(reg_eos), .inj_eoc(inj_eoc), .inj_eos(inj_eos)
  );
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, queue_en = 1'b0;
  logic reg_slot_we = 1'b0, reg_len_we = 1'b0, inj_we = 1'b0;
  logic [3:0] reg_slot_idx = '0, reg_len_in = '0;
  logic [4:0] reg_slot_ch = '0;
  logic [1:0] inj_len_in = '0;
  logic [19:0] inj_chs_in = '0;
  logic reg_start = 1'b0, reg_stop = 1'b0, inj_start = 1'b0, conv_done = 1'b0;
  logic conv_start, res_valid, res_inj, reg_eoc, reg_eos, inj_eoc, inj_eos;
  logic reg_busy, inj_busy, illegal_wr;
  logic [4:0] conv_ch;
  logic [3:0] res_slot;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .queue_en(queue_en),
    .reg_slot_we(reg_slot_we), .reg_slot_idx(reg_slot_idx), .reg_slot_ch(reg_slot_ch),
    .reg_len_we(reg_len_we), .reg_len_in(reg_len_in),
    .inj_we(inj_we), .inj_len_in(inj_len_in), .inj_chs_in(inj_chs_in),
    .reg_start(reg_start), .reg_stop(reg_stop), .inj_start(inj_start), .conv_done(conv_done),
    .conv_start(conv_start), .conv_ch(conv_ch), .res_valid(res_valid), .res_inj(res_inj),
    .res_slot(res_slot), .reg_eoc(reg_eoc), .reg_eos(reg_eos), .inj_eoc(inj_eoc),
    .inj_eos(inj_eos), .reg_busy(reg_busy), .inj_busy(inj_busy), .illegal_wr(illegal_wr)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  int st_n = 0, rs_n = 0, drift = 0;
  int st_ch [64];
  int rs_inj [64], rs_slot [64], rs_eoc [64], rs_eos [64], rs_cross [64];
  int ex_n = 0;
  int ex_ch [64], ex_inj [64], ex_slot [64], ex_last [64];
  int mreg [16];
  int minj [4];
  int mreg_len = 0, minj_len = 0;

  // converter model: fixed-latency done strobe
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        repeat (LAT) @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  // monitor
  initial begin
    bit outst;
    int cur;
    outst = 1'b0;
    cur = 0;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        if (st_n < 64) st_ch[st_n] = int'(conv_ch);
        st_n++;
        outst = 1'b1;
        cur = int'(conv_ch);
      end else if (outst && int'(conv_ch) != cur) begin
        drift++;
      end
      if (res_valid) begin
        outst = 1'b0;
        if (rs_n < 64) begin
          rs_inj[rs_n]   = int'(res_inj);
          rs_slot[rs_n]  = int'(res_slot);
          rs_eoc[rs_n]   = res_inj ? int'(inj_eoc) : int'(reg_eoc);
          rs_eos[rs_n]   = res_inj ? int'(inj_eos) : int'(reg_eos);
          rs_cross[rs_n] = res_inj ? int'(reg_eoc | reg_eos) : int'(inj_eoc | inj_eos);
        end
        rs_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr_log();
    st_n = 0;
    rs_n = 0;
    ex_n = 0;
  endtask

  task automatic push(input int ch, input int inj, input int slot, input int last);
    ex_ch[ex_n] = ch;
    ex_inj[ex_n] = inj;
    ex_slot[ex_n] = slot;
    ex_last[ex_n] = last;
    ex_n++;
  endtask

  task automatic check_log(input string req);
    chk(st_n == ex_n, req, "start count", st_n, ex_n);
    chk(rs_n == ex_n, req, "result count", rs_n, ex_n);
    for (int i = 0; i < ex_n && i < st_n && i < rs_n; i++) begin
      chk(st_ch[i] == ex_ch[i], req, $sformatf("channel of entry %0d", i), st_ch[i], ex_ch[i]);
      chk(rs_inj[i] * 16 + rs_slot[i] == ex_inj[i] * 16 + ex_slot[i], req,
          $sformatf("group*16+slot of entry %0d", i),
          rs_inj[i] * 16 + rs_slot[i], ex_inj[i] * 16 + ex_slot[i]);
      chk(rs_eoc[i] == 1 && rs_cross[i] == 0, "R3", $sformatf("eoc/cross of entry %0d", i),
          rs_eoc[i] * 2 + rs_cross[i], 2);
      chk(rs_eos[i] == ex_last[i], "R4", $sformatf("eos of entry %0d", i), rs_eos[i], ex_last[i]);
    end
  endtask

  task automatic wr_slot(input int i, input int ch);
    @(negedge clk);
    reg_slot_we = 1'b1;
    reg_slot_idx = 4'(i);
    reg_slot_ch = 5'(ch);
    @(negedge clk);
    reg_slot_we = 1'b0;
    mreg[i] = ch;
  endtask

  task automatic wr_len(input int l);
    @(negedge clk);
    reg_len_we = 1'b1;
    reg_len_in = 4'(l);
    @(negedge clk);
    reg_len_we = 1'b0;
    mreg_len = l;
  endtask

  task automatic wr_inj(input int l, input int c0, input int c1, input int c2, input int c3);
    @(negedge clk);
    inj_we = 1'b1;
    inj_len_in = 2'(l);
    inj_chs_in = {5'(c3), 5'(c2), 5'(c1), 5'(c0)};
    @(negedge clk);
    inj_we = 1'b0;
  endtask

  task automatic go_reg();
    @(negedge clk); reg_start = 1'b1;
    @(negedge clk); reg_start = 1'b0;
  endtask

  task automatic go_inj();
    @(negedge clk); inj_start = 1'b1;
    @(negedge clk); inj_start = 1'b0;
  endtask

  task automatic wait_starts(input int n);
    while (st_n < n) @(negedge clk);
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (reg_busy || inj_busy) @(negedge clk);
    repeat (LAT + 6) @(negedge clk);
  endtask

  task automatic disable_pulse(input bit try_start);
    @(negedge clk);
    enable = 1'b0;
    reg_start = try_start;
    inj_start = try_start;
    @(negedge clk);
    reg_start = 1'b0;
    inj_start = 1'b0;
    @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(conv_start == 0 && res_valid == 0, "R11", "start/valid after reset", int'(conv_start) + int'(res_valid), 0);
    chk(reg_busy == 0 && inj_busy == 0 && illegal_wr == 0, "R11", "busy/illegal after reset",
        int'(reg_busy) + int'(inj_busy) + int'(illegal_wr), 0);
    chk(conv_ch == 0, "R11", "conv_ch after reset", int'(conv_ch), 0);
    enable = 1'b1;

    // R1 R3 R4: every regular length
    for (int len = 0; len < 16; len++) begin
      for (int i = 0; i <= len; i++) wr_slot(i, (i * 5 + len * 3) % 19);
      wr_len(len);
      clr_log();
      go_reg();
      wait_idle();
      for (int i = 0; i <= len; i++) push(mreg[i], 0, i, int'(i == len));
      check_log("R1");
      chk(reg_busy == 0, "R4", "regular busy after run", int'(reg_busy), 0);
    end

    // R1 R3 R4: every injected length
    for (int len = 0; len < 4; len++) begin
      for (int i = 0; i < 4; i++) minj[i] = (i * 11 + len + 2) % 19;
      minj_len = len;
      wr_inj(len, minj[0], minj[1], minj[2], minj[3]);
      clr_log();
      go_inj();
      wait_idle();
      for (int i = 0; i <= len; i++) push(minj[i], 1, i, int'(i == len));
      check_log("R1");
      chk(inj_busy == 0, "R4", "injected busy after run", int'(inj_busy), 0);
    end
    chk(illegal_wr == 0, "R6", "no flag after idle writes", int'(illegal_wr), 0);

    // R5: injected preempts regular between conversions
    for (int i = 0; i < 8; i++) wr_slot(i, (i * 3 + 1) % 19);
    wr_len(7);
    for (int i = 0; i < 4; i++) minj[i] = 15 + i;
    wr_inj(2, minj[0], minj[1], minj[2], minj[3]);
    clr_log();
    go_reg();
    wait_starts(3);
    go_inj();
    wait_idle();
    for (int i = 0; i < 3; i++) push(mreg[i], 0, i, 0);
    for (int i = 0; i < 3; i++) push(minj[i], 1, i, int'(i == 2));
    for (int i = 3; i < 8; i++) push(mreg[i], 0, i, int'(i == 7));
    check_log("R5");

    // R10: stop mid-sequence
    wr_len(5);
    clr_log();
    go_reg();
    wait_starts(2);
    @(negedge clk); reg_stop = 1'b1;
    @(negedge clk); reg_stop = 1'b0;
    wait_idle();
    push(mreg[0], 0, 0, 0);
    push(mreg[1], 0, 1, 0);
    check_log("R10");
    chk(reg_busy == 0, "R10", "busy after stop", int'(reg_busy), 0);
    clr_log();
    @(negedge clk); reg_start = 1'b1; reg_stop = 1'b1;
    @(negedge clk); reg_start = 1'b0; reg_stop = 1'b0;
    repeat (6) @(negedge clk);
    chk(reg_busy == 0 && st_n == 0, "R10", "stop wins over start (busy*100+starts)",
        int'(reg_busy) * 100 + st_n, 0);
    go_reg();
    wait_idle();
    for (int i = 0; i < 6; i++) push(mreg[i], 0, i, int'(i == 5));
    check_log("R10");

    // R6: regular write during a run flags but still applies
    wr_len(7);
    clr_log();
    go_reg();
    wait_starts(1);
    wr_slot(6, 18);
    chk(illegal_wr == 1, "R6", "flag after regular write in run", int'(illegal_wr), 1);
    wait_idle();
    for (int i = 0; i < 8; i++) push(mreg[i], 0, i, int'(i == 7));
    check_log("R6");
    chk(illegal_wr == 1, "R6", "flag stays set", int'(illegal_wr), 1);

    // R9: disabling clears the flag and ignores starts
    clr_log();
    disable_pulse(1'b1);
    chk(illegal_wr == 0, "R9", "flag after disable", int'(illegal_wr), 0);
    repeat (6) @(negedge clk);
    chk(reg_busy == 0 && inj_busy == 0 && st_n == 0, "R9", "starts ignored while disabled",
        int'(reg_busy) + int'(inj_busy) + st_n, 0);

    // R7: injected write during a run without the queue
    queue_en = 1'b0;
    for (int i = 0; i < 4; i++) minj[i] = 2 + i;
    wr_inj(3, minj[0], minj[1], minj[2], minj[3]);
    clr_log();
    go_inj();
    wait_starts(1);
    push(minj[0], 1, 0, 0);
    for (int i = 0; i < 4; i++) minj[i] = 10 + i;
    wr_inj(3, minj[0], minj[1], minj[2], minj[3]);
    chk(illegal_wr == 1, "R7", "flag after injected write in run", int'(illegal_wr), 1);
    wait_idle();
    for (int i = 1; i < 4; i++) push(minj[i], 1, i, int'(i == 3));
    check_log("R7");
    disable_pulse(1'b0);

    // R8: queued injected context
    queue_en = 1'b1;
    for (int i = 0; i < 4; i++) minj[i] = 4 + i;
    wr_inj(1, minj[0], minj[1], minj[2], minj[3]);
    clr_log();
    go_inj();
    wait_starts(1);
    wr_inj(3, 17, 16, 9, 0);
    chk(illegal_wr == 0, "R8", "no flag for queued write", int'(illegal_wr), 0);
    wait_idle();
    push(minj[0], 1, 0, 0);
    push(minj[1], 1, 1, 1);
    check_log("R8");
    clr_log();
    go_inj();
    wait_idle();
    push(17, 1, 0, 0);
    push(16, 1, 1, 0);
    push(9, 1, 2, 0);
    push(0, 1, 3, 1);
    check_log("R8");
    chk(illegal_wr == 0, "R8", "flag after context load", int'(illegal_wr), 0);

    chk(drift == 0, "R2", "channel changes while outstanding", drift, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule